// File: doc/BRIEF.md
# Card Detect and Interrupt Conditioner

This block tells a host when a removable memory card has been inserted or pulled out. It can sense presence on the card's DATA3 line, on a dedicated external detect pin, or on both at once. The detect pin has a selectable active level. An optional debounce filter cleans the combined presence signal. Every accepted change of presence, whether insertion or removal, counts as one event.

Each event sets a sticky status flag, which software clears by writing a one to it. The flag drives an interrupt line. The line works either as a level that follows the flag or as a single-clock pulse. Level form and pulse form each have their own active polarity. An event also produces a one-clock active-low wake strobe, but only when both the global wake enable and the interface wake enable are high. The block can also take over the DATA3 pad and drive it as a fixed output. While it does so, the DATA3 line stops counting as a detect source.

Software reaches two 8-bit control registers and one status register through a single-cycle write strobe and a combinational read path.

Top module: `card_detect_cond`

## Requirements
- R1: After reset, register A (address 0) reads 01h, register B (address 1) reads 01h, status (address 2) reads 00h, `irq` is low, `wake_n` is high and `data3_oe` is low.
- R2: Presence is the OR of the enabled sources. A-bit0 enables DATA3, where a high level means a card is present. A-bit1 enables the external pin. A disabled source has no effect on presence or on events.
- R3: A-bit2 sets the external pin's active level. With 0, a low pin means present; with 1, a high pin means present. Changing the bit while the pin is steady is itself an event when it changes presence.
- R4: With A-bit4 set, `data3_oe` is high and `data3_out` equals A-bit5, and the DATA3 level is ignored for detection. With A-bit4 clear, `data3_oe` is low.
- R5: With B-bit0 set, a new presence level is accepted only after it has held for DB_CYCLES consecutive clocks. The status flag sets DB_CYCLES+3 clocks after the pin changes. A shorter glitch causes no event.
- R6: With B-bit0 clear, the status flag sets 4 clocks after a pin change: two synchroniser stages, one filter stage and one event stage.
- R7: Both insertion and removal set status bit0. Status bit1 reads the filtered presence. Address 3 reads 00h.
- R8: Writing 1 to status bit0 clears it, and writing 0 leaves it unchanged. When an event and a clear hit the same clock, the flag stays set.
- R9: With B-bit1 clear (level form), `irq` equals the status flag, inverted when B-bit3 is 1.
- R10: With B-bit1 set (pulse form), `irq` is active for exactly one clock per event, in the same clock the status flag sets. It is active high when B-bit2 is 1 and active low when B-bit2 is 0.
- R11: `wake_n` goes low for exactly one clock per event, in the same clock as the status flag sets, only if `wake_global_en` and `wake_if_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 A, 1 B, 2 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| data3_in | input | 1 | DATA3 pad input level |
| data3_oe | output | 1 | DATA3 pad output enable |
| data3_out | output | 1 | DATA3 pad output level |
| ext_det_in | input | 1 | External card detect pin |
| wake_global_en | input | 1 | Global wake enable |
| wake_if_en | input | 1 | Interface wake enable |
| irq | output | 1 | Interrupt line |
| wake_n | output | 1 | Active-low wake strobe |

## Verification
Two functions can meet in one clock: an event setting the status flag, and a software write that clears the flag. The bench provokes this by changing DATA3 with debounce off. It then raises the clear strobe three clocks later, so the clear is sampled on the same edge that records the event. It reads status afterwards and expects bit0 still set, with the level interrupt still active. A second overlap pairs the event with a wake pulse that has one of its two enables low; there the bench expects the interrupt pulse but no wake strobe.

// File: rtl/card_detect_cond.sv
module card_detect_cond #(
  parameter int DB_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       data3_in,
  output logic       data3_oe,
  output logic       data3_out,
  input  logic       ext_det_in,
  input  logic       wake_global_en,
  input  logic       wake_if_en,
  output logic       irq,
  output logic       wake_n
);
  localparam int CW = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;
  localparam logic [CW-1:0] DB_LAST = CW'(DB_CYCLES - 1);
  localparam logic [7:0] A_MASK = 8'h37;
  localparam logic [7:0] B_MASK = 8'h0F;

  logic [7:0]    ctl_a, ctl_b;
  logic [1:0]    d3_sync, ext_sync;
  logic [CW-1:0] db_cnt;
  logic          raw_pres, pres, pres_d, evt, evt_sts, pulse_q;

  wire wr_a   = reg_wr && (reg_addr == 2'd0);
  wire wr_b   = reg_wr && (reg_addr == 2'd1);
  wire wr_clr = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_a <= 8'h01;
      ctl_b <= 8'h01;
    end else begin
      if (wr_a) ctl_a <= reg_wdata & A_MASK;
      if (wr_b) ctl_b <= reg_wdata & B_MASK;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d3_sync  <= '0;
      ext_sync <= '0;
    end else begin
      d3_sync  <= {d3_sync[0], data3_in};
      ext_sync <= {ext_sync[0], ext_det_in};
    end

  assign raw_pres = (ctl_a[0] & ~ctl_a[4] & d3_sync[1]) |
                    (ctl_a[1] & (ext_sync[1] ~^ ctl_a[2]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pres   <= 1'b0;
      db_cnt <= '0;
    end else if (!ctl_b[0] || raw_pres == pres) begin
      pres   <= raw_pres;
      db_cnt <= '0;
    end else if (db_cnt == DB_LAST) begin
      pres   <= raw_pres;
      db_cnt <= '0;
    end else begin
      db_cnt <= db_cnt + CW'(1);
    end

  assign evt = pres ^ pres_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pres_d  <= 1'b0;
      evt_sts <= 1'b0;
      pulse_q <= 1'b0;
      wake_n  <= 1'b1;
    end else begin
      pres_d  <= pres;
      pulse_q <= evt;
      wake_n  <= ~(evt & wake_global_en & wake_if_en);
      if (evt)         evt_sts <= 1'b1;
      else if (wr_clr) evt_sts <= 1'b0;
    end

  assign irq       = ctl_b[1] ? (pulse_q ~^ ctl_b[2]) : (evt_sts ^ ctl_b[3]);
  assign data3_oe  = ctl_a[4];
  assign data3_out = ctl_a[5];

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = ctl_a;
      2'd1:    reg_rdata = ctl_b;
      2'd2:    reg_rdata = {6'b0, pres, evt_sts};
      default: reg_rdata = 8'h00;
    endcase
endmodule

module card_detect_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       wake_global_en,
  input logic       wake_if_en,
  input logic       wake_n,
  input logic       evt_sts,
  input logic       pres
);
  // R11
  wake_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_n |=> wake_n);

  // R11
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_n |-> $past(wake_global_en && wake_if_en));

  // R8
  sts_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_sts) |-> $past(reg_wr && reg_addr == 2'd2 && reg_wdata[0]));

  // R8
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sts && !(reg_wr && reg_addr == 2'd2 && reg_wdata[0])) |=> evt_sts);

  // R7
  evt_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pres != $past(pres)) |=> evt_sts);
endmodule

bind card_detect_cond card_detect_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .wake_global_en(wake_global_en),
  .wake_if_en(wake_if_en), .wake_n(wake_n), .evt_sts(evt_sts), .pres(pres)
);

// File: tb/card_detect_cond_test.sv
module card_detect_cond_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       data3_in = 1'b0;
  logic       data3_oe, data3_out;
  logic       ext_det_in = 1'b1;
  logic       wake_global_en = 1'b0;
  logic       wake_if_en = 1'b0;
  logic       irq, wake_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    logic  irq;
    logic  wake_n;
    string req;
  } exp_t;
  exp_t q[$];

  card_detect_cond #(.DB_CYCLES(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data3_in(data3_in),
    .data3_oe(data3_oe), .data3_out(data3_out), .ext_det_in(ext_det_in),
    .wake_global_en(wake_global_en), .wake_if_en(wake_if_en),
    .irq(irq), .wake_n(wake_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_at(int at, logic i, logic w, string req);
    exp_t e;
    e.at = at; e.irq = i; e.wake_n = w; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.at < cyc) chk({e.req, " missed slot"}, 8'd1, 8'd0);
      else chk({e.req, " irq/wake_n"}, {6'b0, irq, wake_n}, {6'b0, e.irq, e.wake_n});
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(2'd0, 8'h01, "R1 reg A");
    rd_chk(2'd1, 8'h01, "R1 reg B");
    rd_chk(2'd2, 8'h00, "R1 status");
    rd_chk(2'd3, 8'h00, "R7 unused address");
    chk("R1 irq/wake_n/oe", {5'b0, irq, wake_n, data3_oe}, 8'b010);

    // R5 debounced insertion on DATA3, R9 level active high
    @(negedge clk); data3_in = 1'b1; c = cyc;
    expect_at(c + 6, 1'b0, 1'b1, "R5 before window");
    expect_at(c + 7, 1'b1, 1'b1, "R5 R9 set");
    idle(8);
    rd_chk(2'd2, 8'h03, "R7 insertion status");

    // R8 write-one-to-clear
    wr(2'd2, 8'h00);
    rd_chk(2'd2, 8'h03, "R8 zero write");
    wr(2'd2, 8'h01);
    rd_chk(2'd2, 8'h02, "R8 cleared");
    chk("R9 irq after clear", {7'b0, irq}, 8'h00);

    // R5 short glitch ignored
    @(negedge clk); data3_in = 1'b0;
    idle(2);
    data3_in = 1'b1;
    idle(10);
    rd_chk(2'd2, 8'h02, "R5 glitch");

    // R6 R10 R11 pulse active high, no debounce, wake enabled
    wr(2'd1, 8'h06);
    wake_global_en = 1'b1; wake_if_en = 1'b1;
    @(negedge clk); data3_in = 1'b0; c = cyc;
    expect_at(c + 3, 1'b0, 1'b1, "R6 before");
    expect_at(c + 4, 1'b1, 1'b0, "R10 R11 pulse");
    expect_at(c + 5, 1'b0, 1'b1, "R10 R11 one wide");
    idle(6);
    rd_chk(2'd2, 8'h01, "R7 removal status");

    // R10 pulse active low, R11 wake gated off
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h02);
    wake_if_en = 1'b0;
    chk("R10 idle active-low", {7'b0, irq}, 8'h01);
    @(negedge clk); data3_in = 1'b1; c = cyc;
    expect_at(c + 4, 1'b0, 1'b1, "R10 R11 gated");
    expect_at(c + 5, 1'b1, 1'b1, "R10 end");
    idle(6);

    // R9 level active low
    wr(2'd1, 8'h08);
    chk("R9 low active set", {7'b0, irq}, 8'h00);
    wr(2'd2, 8'h01);
    chk("R9 low idle", {7'b0, irq}, 8'h01);

    // R3 external pin, polarity 0
    @(negedge clk); data3_in = 1'b0;
    idle(6);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h02);
    idle(4);
    rd_chk(2'd2, 8'h00, "R3 pol0 high absent");
    @(negedge clk); ext_det_in = 1'b0; c = cyc;
    expect_at(c + 3, 1'b1, 1'b1, "R3 before");
    expect_at(c + 4, 1'b0, 1'b1, "R3 pol0 low present");
    idle(6);
    rd_chk(2'd2, 8'h03, "R3 present");
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h06);
    idle(2);
    rd_chk(2'd2, 8'h01, "R3 pol1 low absent");

    // R2 disabled DATA3 ignored
    wr(2'd2, 8'h01);
    @(negedge clk); data3_in = 1'b1;
    idle(6);
    rd_chk(2'd2, 8'h00, "R2 disabled source");
    chk("R2 irq idle", {7'b0, irq}, 8'h01);

    // R2 both sources OR
    wr(2'd0, 8'h07);
    idle(2);
    rd_chk(2'd2, 8'h03, "R2 data3 alone");
    wr(2'd2, 8'h01);
    @(negedge clk); data3_in = 1'b0;
    idle(6);
    rd_chk(2'd2, 8'h01, "R2 both absent");
    @(negedge clk); ext_det_in = 1'b1;
    idle(6);
    rd_chk(2'd2, 8'h03, "R2 ext alone");

    // R4 forced DATA3 output
    wr(2'd0, 8'h31);
    idle(3);
    wr(2'd2, 8'h01);
    chk("R4 oe/out high", {6'b0, data3_oe, data3_out}, 8'h03);
    @(negedge clk); data3_in = 1'b1;
    idle(6);
    rd_chk(2'd2, 8'h00, "R4 forced ignores DATA3");
    wr(2'd0, 8'h11);
    chk("R4 oe/out low", {6'b0, data3_oe, data3_out}, 8'h02);

    // R8 event and clear in same clock
    wr(2'd0, 8'h01);
    idle(3);
    wr(2'd2, 8'h01);
    rd_chk(2'd2, 8'h02, "R8 pre overlap");
    @(negedge clk); data3_in = 1'b0; c = cyc;
    idle(3);
    reg_addr = 2'd2; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd_chk(2'd2, 8'h01, "R8 set wins");
    chk("R8 R9 irq active", {7'b0, irq}, 8'h00);
    chk("R4 pad released", {7'b0, data3_oe}, 8'h00);

    idle(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule